// File: doc/BRIEF.md
# Half-Merging Load/Store Unit

This block runs one memory-transfer instruction at a time. An 18-bit instruction is handed over with a one-cycle `start` pulse. The unit reads three registers from an external 8-entry register file: two address operands and the data register X. It forms an effective address with a small ALU whose lane mode shapes the result. It then makes one access to a single-port synchronous memory that returns read data one cycle after the request.

A transfer moves either a whole 18-bit word or one 9-bit half. A half load replaces only the matching half of X and keeps the other half. A half store raises only the matching write-enable bit, so the other half of the memory word is left as it was. Stores never write the register file. Every accepted instruction takes five cycles and ends with a one-cycle `done` pulse.

Top module: `lsu_top`

## Requirements
- R1: While reset is held, and afterwards until an instruction is accepted, `done`, `mem_en`, `rf_we` and `mem_we` are all low.
- R2: An instruction is accepted only when the unit is idle and `start` is high. The accepting clock edge opens cycle 1. The memory request (`mem_en`) is high in cycle 3 only, and `done` is high in cycle 5 only. A `start` seen while the unit is busy is dropped and causes no second access.
- R3: Instruction layout, from the top bit down: bit 17 = 1, bits 16:15 = mode, bits 14:12 = transfer code, bits 11:9 = X index, bits 8:6 = ALU code, bits 5:3 = A index, bits 2:0 = B index. A `start` with bit 17 clear, or with transfer code 000 or 111, is ignored: no memory request, no `done`, no register write.
- R4: Binary ALU codes compute the address from A and B: 000 add, 001 subtract (A−B), 010 AND, 011 OR, 100 XOR.
- R5: ALU code 111 is unary on A, with bits 2:0 picking the operation: 000 invert, 001 shift right by one, 010 add one to each half (constant 0x201), 011 subtract that constant, 100 increment, 101 decrement.
- R6: Mode 00 treats the word as one 18-bit number, so carries and borrows cross bit 9. Mode 01 treats it as two independent 9-bit lanes with no carry between them. In lane mode, increment and decrement touch only the lower lane.
- R7: Mode 10 keeps the lower lane result and zeroes the upper half. Mode 11 keeps the upper lane result and zeroes the lower half. The mode shapes only the address; the amount of data moved is set by the transfer code.
- R8: Transfer code 001 loads the whole addressed word into X.
- R9: Transfer code 010 replaces bits 8:0 of X with bits 8:0 of the memory word. Code 011 replaces bits 17:9 of X with bits 17:9 of the memory word. The other half of X is kept.
- R10: Transfer code 100 writes the whole of X to the addressed word, with `mem_we` = 11 and `mem_wdata` = X.
- R11: Transfer code 101 writes only bits 8:0 (`mem_we` = 01). Code 110 writes only bits 17:9 (`mem_we` = 10). The other half of the memory word is kept, and no store writes the register file.
- R12: ALU codes 101 and 110, and unary selectors 110 and 111, give address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid pulse |
| instr | input | 18 | Instruction word |
| done | output | 1 | Completion pulse in cycle 5 |
| rf_ra_a | output | 3 | Register file read index for A |
| rf_ra_b | output | 3 | Register file read index for B |
| rf_ra_x | output | 3 | Register file read index for X |
| rf_rd_a | input | 18 | Read data for A |
| rf_rd_b | input | 18 | Read data for B |
| rf_rd_x | input | 18 | Read data for X |
| rf_we | output | 1 | Register file write enable (loads only) |
| rf_wa | output | 3 | Register file write index |
| rf_wd | output | 18 | Register file write data |
| mem_en | output | 1 | Memory request |
| mem_we | output | 2 | Half write enables: bit 0 = bits 8:0, bit 1 = bits 17:9 |
| mem_addr | output | 18 | Memory address |
| mem_wdata | output | 18 | Memory write data |
| mem_rdata | input | 18 | Memory read data, valid one cycle after the request |

## Verification
The bench builds the unit with its defaults: an 18-bit word and the carry-kill adder variant, which inserts a blocking bit between the lanes. This choice puts the lane boundary at bit 9. Operands with an all-ones lower half therefore show the carry crossing bit 9 in flat mode and stopping there in lane mode. The register file and the memory are behavioural models in the bench. After every transfer, the bench compares the whole X word or the whole memory word, so a damaged neighbouring half shows up. It also checks that starts arriving mid-operation and unusable instruction codes produce no memory traffic.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   localparam int INSTR_W = 18;
   localparam int RIDX_W  = 3;

   typedef enum logic [2:0] {
      XF_NONE = 3'b000,
      XF_LDW  = 3'b001,
      XF_LDL  = 3'b010,
      XF_LDU  = 3'b011,
      XF_STW  = 3'b100,
      XF_STL  = 3'b101,
      XF_STU  = 3'b110,
      XF_RSV  = 3'b111
   } xfer_e;

   typedef enum logic [1:0] {
      AM_FLAT = 2'b00,
      AM_LANE = 2'b01,
      AM_LOW  = 2'b10,
      AM_HIGH = 2'b11
   } amode_e;

   typedef enum logic [2:0] {
      RS_SUM,
      RS_AND,
      RS_OR,
      RS_XOR,
      RS_NOT,
      RS_SHR,
      RS_ZERO
   } rsel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEC,
      ST_AGU,
      ST_REQ,
      ST_DAT,
      ST_WB
   } lsu_st_e;

   localparam logic [2:0] ALU_ADD   = 3'b000;
   localparam logic [2:0] ALU_SUB   = 3'b001;
   localparam logic [2:0] ALU_AND   = 3'b010;
   localparam logic [2:0] ALU_OR    = 3'b011;
   localparam logic [2:0] ALU_XOR   = 3'b100;
   localparam logic [2:0] ALU_UNARY = 3'b111;

   localparam logic [2:0] UN_NOT  = 3'b000;
   localparam logic [2:0] UN_SHR  = 3'b001;
   localparam logic [2:0] UN_PINC = 3'b010;
   localparam logic [2:0] UN_PDEC = 3'b011;
   localparam logic [2:0] UN_INC  = 3'b100;
   localparam logic [2:0] UN_DEC  = 3'b101;

   function automatic logic xf_usable(logic [2:0] code);
      return (code != XF_NONE) && (code != XF_RSV);
   endfunction

   function automatic logic xf_is_load(logic [2:0] code);
      return (code == XF_LDW) || (code == XF_LDL) || (code == XF_LDU);
   endfunction

   function automatic logic [1:0] xf_halves(logic [2:0] code);
      logic [1:0] h;
      case (code)
         XF_LDL, XF_STL: h = 2'b01;
         XF_LDU, XF_STU: h = 2'b10;
         XF_LDW, XF_STW: h = 2'b11;
         default:        h = 2'b00;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
   import lsu_pkg::*;
(
   input  logic [INSTR_W-2:0] fields,
   output amode_e             mode,
   output logic [2:0]         xcode,
   output logic [RIDX_W-1:0]  xidx,
   output logic [2:0]         aluop,
   output logic [RIDX_W-1:0]  aidx,
   output logic [RIDX_W-1:0]  bidx,
   output logic               is_load,
   output logic [1:0]         halves
);

   always_comb begin
      mode    = amode_e'(fields[16:15]);
      xcode   = fields[14:12];
      xidx    = fields[11:9];
      aluop   = fields[8:6];
      aidx    = fields[5:3];
      bidx    = fields[2:0];
      is_load = xf_is_load(xcode);
      halves  = xf_halves(xcode);
   end

endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
   import lsu_pkg::*;
#(
   parameter int WORD_W      = 18,
   parameter int ADDER_STYLE = 0
) (
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   input  logic [2:0]        aluop,
   input  logic [2:0]        usel,
   input  amode_e            mode,
   output logic [WORD_W-1:0] addr
);

   localparam int H = WORD_W / 2;
   localparam logic [WORD_W-1:0] ONE_W  = WORD_W'(1);
   localparam logic [WORD_W-1:0] PAIR_W = ONE_W | (ONE_W << H);

   if ((WORD_W % 2) != 0 || WORD_W < 4) begin : g_bad_width
      $error("lsu_agu: WORD_W must be even and at least 4");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("lsu_agu: ADDER_STYLE must be 0 or 1");
   end

   rsel_e             rsel;
   logic              sub;
   logic [WORD_W-1:0] bop;
   logic [WORD_W-1:0] beff;
   logic [WORD_W-1:0] flat_sum;
   logic [WORD_W-1:0] lane_sum;
   logic [WORD_W-1:0] flat_shr;
   logic [WORD_W-1:0] lane_shr;
   logic [WORD_W-1:0] res;
   logic              lanes;

   always_comb begin
      rsel = RS_ZERO;
      sub  = 1'b0;
      bop  = opb;
      case (aluop)
         ALU_ADD: rsel = RS_SUM;
         ALU_SUB: begin rsel = RS_SUM; sub = 1'b1; end
         ALU_AND: rsel = RS_AND;
         ALU_OR:  rsel = RS_OR;
         ALU_XOR: rsel = RS_XOR;
         ALU_UNARY: begin
            case (usel)
               UN_NOT:  rsel = RS_NOT;
               UN_SHR:  rsel = RS_SHR;
               UN_PINC: begin rsel = RS_SUM; bop = PAIR_W; end
               UN_PDEC: begin rsel = RS_SUM; bop = PAIR_W; sub = 1'b1; end
               UN_INC:  begin rsel = RS_SUM; bop = ONE_W; end
               UN_DEC:  begin rsel = RS_SUM; bop = ONE_W; sub = 1'b1; end
               default: rsel = RS_ZERO;
            endcase
         end
         default: rsel = RS_ZERO;
      endcase
   end

   assign beff     = sub ? ~bop : bop;
   assign flat_sum = opa + beff + {{(WORD_W-1){1'b0}}, sub};
   assign flat_shr = {1'b0, opa[WORD_W-1:1]};
   assign lane_shr = {1'b0, opa[WORD_W-1:H+1], 1'b0, opa[H-1:1]};

   if (ADDER_STYLE == 0) begin : g_killbit
      logic [WORD_W:0] wide;
      assign wide = {opa[WORD_W-1:H], sub, opa[H-1:0]}
                  + {beff[WORD_W-1:H], sub, beff[H-1:0]}
                  + {{WORD_W{1'b0}}, sub};
      assign lane_sum = {wide[WORD_W:H+1], wide[H-1:0]};
   end else begin : g_split
      logic [H-1:0] lo;
      logic [H-1:0] hi;
      assign lo = opa[H-1:0] + beff[H-1:0] + {{(H-1){1'b0}}, sub};
      assign hi = opa[WORD_W-1:H] + beff[WORD_W-1:H] + {{(H-1){1'b0}}, sub};
      assign lane_sum = {hi, lo};
   end

   assign lanes = (mode != AM_FLAT);

   always_comb begin
      case (rsel)
         RS_SUM:  res = lanes ? lane_sum : flat_sum;
         RS_AND:  res = opa & opb;
         RS_OR:   res = opa | opb;
         RS_XOR:  res = opa ^ opb;
         RS_NOT:  res = ~opa;
         RS_SHR:  res = lanes ? lane_shr : flat_shr;
         default: res = '0;
      endcase
      case (mode)
         AM_LOW:  addr = {{H{1'b0}}, res[H-1:0]};
         AM_HIGH: addr = {res[WORD_W-1:H], {H{1'b0}}};
         default: addr = res;
      endcase
   end

endmodule

// File: rtl/lsu_merge.sv
module lsu_merge #(
   parameter int WORD_W = 18
) (
   input  logic [WORD_W-1:0] keep_val,
   input  logic [WORD_W-1:0] new_val,
   input  logic [1:0]        take,
   output logic [WORD_W-1:0] merged
);

   localparam int H = WORD_W / 2;

   for (genvar g = 0; g < 2; g++) begin : g_half
      assign merged[g*H +: H] = take[g] ? new_val[g*H +: H] : keep_val[g*H +: H];
   end

endmodule

// File: rtl/lsu_top.sv
module lsu_top
   import lsu_pkg::*;
#(
   parameter int WORD_W      = 18,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [17:0]       instr,
   output logic              done,
   output logic [2:0]        rf_ra_a,
   output logic [2:0]        rf_ra_b,
   output logic [2:0]        rf_ra_x,
   input  logic [WORD_W-1:0] rf_rd_a,
   input  logic [WORD_W-1:0] rf_rd_b,
   input  logic [WORD_W-1:0] rf_rd_x,
   output logic              rf_we,
   output logic [2:0]        rf_wa,
   output logic [WORD_W-1:0] rf_wd,
   output logic              mem_en,
   output logic [1:0]        mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata
);

   localparam int H = WORD_W / 2;

   if ((WORD_W % 2) != 0 || WORD_W < 4) begin : g_bad_width
      $error("lsu_top: WORD_W must be even and at least 4");
   end

   lsu_st_e             st;
   logic [INSTR_W-2:0]  iq;
   logic [WORD_W-1:0]   a_q, b_q, x_q, addr_q, rdat_q;
   logic                accept;

   amode_e              mode;
   logic [2:0]          xcode, aluop;
   logic [RIDX_W-1:0]   xidx, aidx, bidx;
   logic                is_load;
   logic [1:0]          halves;
   logic [WORD_W-1:0]   agu_addr;
   logic [WORD_W-1:0]   wb_val;

   assign accept = (st == ST_IDLE) && start && instr[17] && xf_usable(instr[14:12]);

   lsu_decode u_dec (
      .fields  (iq),
      .mode    (mode),
      .xcode   (xcode),
      .xidx    (xidx),
      .aluop   (aluop),
      .aidx    (aidx),
      .bidx    (bidx),
      .is_load (is_load),
      .halves  (halves)
   );

   lsu_agu #(.WORD_W(WORD_W), .ADDER_STYLE(ADDER_STYLE)) u_agu (
      .opa   (a_q),
      .opb   (b_q),
      .aluop (aluop),
      .usel  (bidx),
      .mode  (mode),
      .addr  (agu_addr)
   );

   lsu_merge #(.WORD_W(WORD_W)) u_mrg (
      .keep_val (x_q),
      .new_val  (rdat_q),
      .take     (halves),
      .merged   (wb_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         iq     <= '0;
         a_q    <= '0;
         b_q    <= '0;
         x_q    <= '0;
         addr_q <= '0;
         rdat_q <= '0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               iq <= instr[16:0];
               st <= ST_DEC;
            end
            ST_DEC: begin
               a_q <= rf_rd_a;
               b_q <= rf_rd_b;
               x_q <= rf_rd_x;
               st  <= ST_AGU;
            end
            ST_AGU: begin
               addr_q <= agu_addr;
               st     <= ST_REQ;
            end
            ST_REQ: st <= ST_DAT;
            ST_DAT: begin
               rdat_q <= mem_rdata;
               st     <= ST_WB;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rf_ra_a   = aidx;
   assign rf_ra_b   = bidx;
   assign rf_ra_x   = xidx;
   assign mem_en    = (st == ST_REQ);
   assign mem_we    = (st == ST_REQ && !is_load) ? halves : 2'b00;
   assign mem_addr  = addr_q;
   assign mem_wdata = x_q;
   assign done      = (st == ST_WB);
   assign rf_we     = (st == ST_WB) && is_load;
   assign rf_wa     = xidx;
   assign rf_wd     = wb_val;

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_req_two_before_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_en, 2));
   a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |=> !mem_en);
   a_r3_bad_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && !(instr[17] && xf_usable(instr[14:12]))) |=> !mem_en && !done);
   a_r10_write_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we != 2'b00) |-> mem_en);
   a_r11_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mem_we, 2) != 2'b00) |-> !rf_we);
   a_r7_low_mode_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mode == AM_LOW) |-> mem_addr[WORD_W-1:H] == '0);
   a_r7_high_mode_lower_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mode == AM_HIGH) |-> mem_addr[H-1:0] == '0);

endmodule

// File: tb/sim_lsu_top.sv
module sim_lsu_top;

   typedef struct {
      logic        is_load;
      logic [2:0]  wa;
      logic [17:0] val;
      logic [17:0] addr;
      string       req;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [17:0] instr = '0;
   logic        done, rf_we, mem_en;
   logic [2:0]  rf_ra_a, rf_ra_b, rf_ra_x, rf_wa;
   logic [17:0] rf_rd_a, rf_rd_b, rf_rd_x, rf_wd;
   logic [1:0]  mem_we;
   logic [17:0] mem_addr, mem_wdata;
   logic [17:0] mem_rdata = '0;

   logic [17:0] rf [8];
   logic [17:0] mem [logic [17:0]];

   sb_item_t    sbq [$];
   int          n_chk = 0;
   int          n_bad = 0;
   int          n_done = 0;
   int          n_req = 0;
   logic [17:0] last_addr = '0;
   bit          finished = 0;

   always #10 clk = ~clk;

   lsu_top u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .done(done),
      .rf_ra_a(rf_ra_a), .rf_ra_b(rf_ra_b), .rf_ra_x(rf_ra_x),
      .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b), .rf_rd_x(rf_rd_x),
      .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign rf_rd_a = rf[rf_ra_a];
   assign rf_rd_b = rf[rf_ra_b];
   assign rf_rd_x = rf[rf_ra_x];

   function automatic logic [17:0] mem_get(logic [17:0] a);
      return mem.exists(a) ? mem[a] : 18'h0;
   endfunction

   always @(posedge clk) begin
      if (rf_we) rf[rf_wa] = rf_wd;
      if (mem_en) begin
         logic [17:0] cur;
         cur = mem_get(mem_addr);
         mem_rdata <= cur;
         if (mem_we[0]) cur[8:0]  = mem_wdata[8:0];
         if (mem_we[1]) cur[17:9] = mem_wdata[17:9];
         if (mem_we != 2'b00) mem[mem_addr] = cur;
      end
   end

   task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // lane-wise reference of the address ALU on one 9-bit half
   function automatic logic [8:0] lane_op(logic [8:0] x, logic [8:0] y, logic [2:0] alu,
                                          logic [2:0] sel, bit upper);
      case (alu)
         3'd0: return x + y;
         3'd1: return x - y;
         3'd2: return x & y;
         3'd3: return x | y;
         3'd4: return x ^ y;
         3'd7: case (sel)
            3'd0: return ~x;
            3'd1: return x >> 1;
            3'd2: return x + 9'd1;
            3'd3: return x - 9'd1;
            3'd4: return upper ? x : x + 9'd1;
            3'd5: return upper ? x : x - 9'd1;
            default: return 9'd0;
         endcase
         default: return 9'd0;
      endcase
   endfunction

   function automatic logic [17:0] flat_op(logic [17:0] x, logic [17:0] y, logic [2:0] alu, logic [2:0] sel);
      case (alu)
         3'd0: return x + y;
         3'd1: return x - y;
         3'd2: return x & y;
         3'd3: return x | y;
         3'd4: return x ^ y;
         3'd7: case (sel)
            3'd0: return ~x;
            3'd1: return x >> 1;
            3'd2: return x + 18'h00201;
            3'd3: return x - 18'h00201;
            3'd4: return x + 18'd1;
            3'd5: return x - 18'd1;
            default: return 18'd0;
         endcase
         default: return 18'd0;
      endcase
   endfunction

   function automatic logic [17:0] ref_addr(logic [1:0] mm, logic [2:0] alu, logic [2:0] a, logic [2:0] b);
      logic [17:0] lanes;
      lanes = {lane_op(rf[a][17:9], rf[b][17:9], alu, b, 1'b1),
               lane_op(rf[a][8:0],  rf[b][8:0],  alu, b, 1'b0)};
      case (mm)
         2'd0: return flat_op(rf[a], rf[b], alu, b);
         2'd1: return lanes;
         2'd2: return {9'd0, lanes[8:0]};
         default: return {lanes[17:9], 9'd0};
      endcase
   endfunction

   // driver: predict, push to scoreboard, run the instruction, measure latency
   task automatic issue(input logic [1:0] mm, input logic [2:0] op, input logic [2:0] x,
                        input logic [2:0] alu, input logic [2:0] a, input logic [2:0] b,
                        input string req);
      sb_item_t it;
      logic [17:0] w, m;
      int lat;
      it.addr = ref_addr(mm, alu, a, b);
      m = mem_get(it.addr);
      w = rf[x];
      it.is_load = (op <= 3'd3);
      it.wa = x;
      it.req = req;
      case (op)
         3'd1: it.val = m;
         3'd2: it.val = {w[17:9], m[8:0]};
         3'd3: it.val = {m[17:9], w[8:0]};
         3'd4: it.val = w;
         3'd5: it.val = {m[17:9], w[8:0]};
         default: it.val = {w[17:9], m[8:0]};
      endcase
      sbq.push_back(it);
      @(negedge clk);
      start = 1'b1;
      instr = {1'b1, mm, op, x, alu, a, b};
      @(posedge clk);
      lat = 0;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (done && lat == 0) lat = k;
      end
      check(lat == 5, {"R2 latency ", req}, 18'(lat), 18'd5);
   endtask

   // monitor: pop and compare at each done pulse
   always @(negedge clk) begin
      if (mem_en) begin
         last_addr = mem_addr;
         n_req++;
      end
      if (done) begin
         n_done++;
         if (sbq.size() == 0) begin
            check(1'b0, "R2 unexpected done", 18'd1, 18'd0);
         end else begin
            sb_item_t it;
            it = sbq.pop_front();
            check(last_addr == it.addr, {it.req, " address"}, last_addr, it.addr);
            if (it.is_load) begin
               check(rf_we && rf_wa == it.wa && rf_wd == it.val, {it.req, " load value"}, rf_wd, it.val);
            end else begin
               check(!rf_we, {"R11 store writes no register ", it.req}, 18'(rf_we), 18'd0);
               check(mem_get(last_addr) == it.val, {it.req, " stored word"}, mem_get(last_addr), it.val);
            end
         end
      end
   end

   task automatic quiet_start(input logic [17:0] word, input string req);
      int d0, r0;
      logic [17:0] x_before;
      d0 = n_done;
      r0 = n_req;
      x_before = rf[3];
      @(negedge clk);
      start = 1'b1;
      instr = word;
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      check(n_done == d0 && n_req == r0, req, 18'(n_done - d0 + n_req - r0), 18'd0);
      check(rf[3] == x_before, {req, " register kept"}, rf[3], x_before);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      check(1'b0, "watchdog expired", 18'd0, 18'd1);
      finish_run();
   end

   initial begin
      rf[0] = 18'h00000; rf[1] = 18'h0A1FF; rf[2] = 18'h00001; rf[3] = 18'h2C0B5;
      rf[4] = 18'h15555; rf[5] = 18'h3ABCD; rf[6] = 18'h00000; rf[7] = 18'h00200;
      mem[18'h0A200] = 18'h1F0F0;
      mem[18'h0A000] = 18'h2468A;
      mem[18'h2C0B4] = 18'h13579;
      mem[18'h00000] = 18'h0BEEF;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!done && !mem_en && !rf_we && mem_we == 2'b00, "R1 outputs during reset",
            {14'd0, done, mem_en, mem_we}, 18'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !mem_en && !rf_we && mem_we == 2'b00, "R1 outputs idle after reset",
            {14'd0, done, mem_en, mem_we}, 18'd0);

      issue(2'd0, 3'd1, 3'd6, 3'd0, 3'd1, 3'd2, "R8 R6 flat add carries across halves");
      issue(2'd1, 3'd1, 3'd6, 3'd0, 3'd1, 3'd2, "R6 lane add keeps halves apart");
      issue(2'd0, 3'd2, 3'd5, 3'd1, 3'd3, 3'd2, "R9 R4 lower-half load via subtract");
      issue(2'd0, 3'd3, 3'd5, 3'd4, 3'd3, 3'd4, "R9 R4 upper-half load via xor");
      issue(2'd2, 3'd1, 3'd6, 3'd2, 3'd1, 3'd3, "R7 R4 low mode and, full word loaded");
      issue(2'd3, 3'd1, 3'd6, 3'd3, 3'd1, 3'd2, "R7 R4 high mode or, full word loaded");
      issue(2'd0, 3'd4, 3'd5, 3'd7, 3'd7, 3'd4, "R10 R5 word store via increment");
      issue(2'd1, 3'd5, 3'd3, 3'd7, 3'd4, 3'd0, "R11 R5 lower-half store via lane invert");
      issue(2'd1, 3'd6, 3'd1, 3'd7, 3'd3, 3'd1, "R11 R5 upper-half store via lane shift");
      issue(2'd0, 3'd1, 3'd6, 3'd7, 3'd3, 3'd1, "R5 flat shift");
      issue(2'd0, 3'd1, 3'd6, 3'd7, 3'd1, 3'd2, "R5 pair increment");
      issue(2'd1, 3'd1, 3'd6, 3'd7, 3'd7, 3'd3, "R5 R6 lane pair decrement");
      issue(2'd1, 3'd1, 3'd6, 3'd7, 3'd7, 3'd5, "R5 R6 lane decrement");
      issue(2'd1, 3'd1, 3'd6, 3'd7, 3'd1, 3'd4, "R6 lane increment wraps lower only");
      issue(2'd0, 3'd2, 3'd5, 3'd5, 3'd1, 3'd4, "R12 reserved alu code gives address 0");
      issue(2'd0, 3'd3, 3'd5, 3'd7, 3'd1, 3'd7, "R12 reserved unary selector gives address 0");

      quiet_start({1'b1, 2'd0, 3'd0, 3'd3, 3'd0, 3'd1, 3'd2}, "R3 transfer code 000 ignored");
      quiet_start({1'b1, 2'd0, 3'd7, 3'd3, 3'd0, 3'd1, 3'd2}, "R3 transfer code 111 ignored");
      quiet_start({1'b0, 2'd0, 3'd1, 3'd3, 3'd0, 3'd1, 3'd2}, "R3 top bit clear ignored");

      // R2: start while busy is dropped
      begin
         sb_item_t it;
         int d0, r0;
         d0 = n_done;
         r0 = n_req;
         it.addr = ref_addr(2'd0, 3'd0, 3'd1, 3'd2);
         it.is_load = 1'b1;
         it.wa = 3'd6;
         it.val = mem_get(it.addr);
         it.req = "R2 busy op";
         sbq.push_back(it);
         @(negedge clk);
         start = 1'b1;
         instr = {1'b1, 2'd0, 3'd1, 3'd6, 3'd0, 3'd1, 3'd2};
         @(negedge clk);
         instr = {1'b1, 2'd0, 3'd4, 3'd5, 3'd7, 3'd0, 3'd4};
         @(negedge clk);
         @(negedge clk);
         start = 1'b0;
         repeat (10) @(negedge clk);
         check(n_done - d0 == 1, "R2 one done for one accepted start", 18'(n_done - d0), 18'd1);
         check(n_req - r0 == 1, "R2 one memory request", 18'(n_req - r0), 18'd1);
         check(!mem.exists(18'h00001), "R2 dropped store left memory alone", mem_get(18'h00001), 18'd0);
      end

      check(sbq.size() == 0, "R2 every issued op completed", 18'(sbq.size()), 18'd0);
      finish_run();
   end

endmodule